// File: doc/BRIEF.md
# Sectioned Clock Register Access Controller

This block is the register-side engine behind a two-wire serial slave. The serial front end turns the wire protocol into one-cycle byte events: start, stop, device select byte, address byte, write data byte and read request. This controller turns those events into accesses to a 64-location clock/control space. The space is split into fixed sections: two alarm sections, a control section, a time-counter section and a single status byte.

Burst accesses move through a section and wrap back to its first address, so an operation never leaves the section it started in. Incoming write data is parked in a buffer. It reaches the registers only when the stop condition arrives, and only after a two-step write-enable handshake has been performed through the status byte. At the beginning of every read, the live time counters are copied into a snapshot, so a multi-byte read of the time cannot tear. A bytewise load request with a byte mask sends committed time values to the external timekeeper.

Top module: `ccr_access_ctl`

## Requirements
- R1: An operation is selected only when the upper seven bits of the device byte are 1101111; bit 0 gives the direction (1 = read). With any other device byte, every following address, data and read event until the next start or stop is ignored: no data byte is buffered and rd_valid stays low.
- R2: An address byte above 0x3F deselects the write operation. The pointer keeps its previous value and the data bytes that follow are dropped.
- R3: The address map is fixed. Alarm A is at 0x00–0x07, alarm B at 0x08–0x0F, control at 0x10–0x13, the time counters at 0x30–0x37 and status at 0x3F. After each byte of a burst the pointer advances, and after the last address of a section it returns to that section's first address.
- R4: Status takes only one byte per operation. A second write byte is ignored, and the first byte still takes effect at stop. A second read request returns nothing (rd_valid low). Both end the operation.
- R5: A status write of 0x02 sets WEL only. A status write of 0x06 while WEL is set sets both WEL and RWEL. Any other status byte clears both. Reading status returns WEL in bit 1, RWEL in bit 2 and zero in every other bit. Status writes take effect at stop without needing RWEL.
- R6: Writes to the alarm, control and time sections are buffered. They are committed at stop only if RWEL is set, and discarded otherwise. A start that arrives before the stop discards the buffer.
- R7: A committed time-section write gives a one-cycle tc_load pulse in the cycle after the stop. tc_load_data byte i (bits 8i+7:8i) holds the value written to address 0x30+i, and tc_load_mask bit i marks the bytes that were written.
- R8: The time counters are copied from tc_live when a read device byte is accepted. All time bytes returned in that operation come from this copy, even if tc_live changes.
- R9: The pointer persists across operations. A read that has no address byte (current-address read) starts where the last access left the pointer.
- R10: Addresses outside the sections read as 0x00. Writes to them have no effect, and the pointer does not move while it sits on one.
- R11: After reset all alarm, control and enable state reads as zero, the pointer is 0x00, and rd_valid and tc_load are low.
- R12: rd_data and rd_valid are presented in the cycle after the accepted read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Start or repeated start seen |
| ev_stop | input | 1 | Stop seen |
| ev_dev | input | 1 | Device select byte valid |
| dev_byte | input | 8 | Device select byte |
| ev_addr | input | 1 | Address byte valid |
| addr_byte | input | 8 | Register address byte |
| ev_wdat | input | 1 | Write data byte valid |
| wdat | input | 8 | Write data byte |
| ev_rreq | input | 1 | Next read byte requested |
| tc_live | input | 64 | Live time counters, byte i = address 0x30+i |
| rd_data | output | 8 | Read data |
| rd_valid | output | 1 | Read data valid |
| tc_load | output | 1 | Committed time write pulse |
| tc_load_data | output | 64 | Time bytes to load |
| tc_load_mask | output | 8 | Which time bytes to load |

## Verification
The hardest state to reach from the ports is a commit that actually lands. It needs RWEL set, and that takes two status operations in the right order, each closed by a stop, before a burst is closed by a stop and not by a repeated start. The random stimulus mixes enable-arm, enable-set and enable-clear status writes with bursts that start at random offsets in every section. This means the enable state is already set for many bursts, and those bursts wrap at section ends. Snapshot consistency is reached by changing tc_live between every pair of read requests inside time-section reads.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int ADDR_W = 6;
  localparam int DW     = 8;
  localparam int OFF_W  = 3;
  localparam logic [6:0] SEL_CODE = 7'b1101111;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 6'h3F;
  localparam int WEL_POS  = 1;
  localparam int RWEL_POS = 2;
  localparam logic [DW-1:0] ARM_CODE = DW'(1 << WEL_POS);
  localparam logic [DW-1:0] SET_CODE = DW'((1 << WEL_POS) | (1 << RWEL_POS));

  typedef enum logic [2:0] {
    SEC_AL0, SEC_AL1, SEC_CTL, SEC_TC, SEC_STAT, SEC_NONE
  } sec_e;

  // Decode which section an address belongs to.
  function automatic sec_e sec_of(logic [ADDR_W-1:0] a);
    if (a[5:4] == 2'b00)   return a[3] ? SEC_AL1 : SEC_AL0;
    if (a[5:2] == 4'b0100) return SEC_CTL;
    if (a[5:3] == 3'b110)  return SEC_TC;
    if (a == STAT_ADDR)    return SEC_STAT;
    return SEC_NONE;
  endfunction

  // Next pointer value, wrapping inside the current section.
  function automatic logic [ADDR_W-1:0] next_ptr(logic [ADDR_W-1:0] a);
    case (sec_of(a))
      SEC_AL0, SEC_AL1, SEC_TC: return {a[5:3], a[2:0] + 3'd1};
      SEC_CTL:                  return {a[5:2], a[1:0] + 2'd1};
      default:                  return a;
    endcase
  endfunction

  function automatic logic buffered_sec(sec_e s);
    return (s == SEC_AL0) || (s == SEC_AL1) || (s == SEC_CTL) || (s == SEC_TC);
  endfunction
endpackage

// File: rtl/ccr_ptr.sv
module ccr_ptr
  import ccr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_addr;
    else if (adv)  ptr <= next_ptr(ptr);
  end
endmodule

// File: rtl/ccr_enable.sv
module ccr_enable
  import ccr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [DW-1:0] val,
  output logic          wel,
  output logic          rwel
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      rwel <= 1'b0;
    end else if (upd) begin
      if (val == ARM_CODE) begin
        wel  <= 1'b1;
        rwel <= 1'b0;
      end else if (val == SET_CODE && wel) begin
        wel  <= 1'b1;
        rwel <= 1'b1;
      end else begin
        wel  <= 1'b0;
        rwel <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ccr_wbuf.sv
module ccr_wbuf
  import ccr_pkg::*;
#(
  parameter int SLOTS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  wr,
  input  logic [OFF_W-1:0]      off,
  input  logic [DW-1:0]         din,
  input  sec_e                  sec_in,
  output logic [SLOTS*DW-1:0]   data,
  output logic [SLOTS-1:0]      mask,
  output sec_e                  sec
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask[i]          <= 1'b0;
        data[i*DW +: DW] <= '0;
      end else if (clr) begin
        mask[i] <= 1'b0;
      end else if (wr && off == OFF_W'(i)) begin
        mask[i]          <= 1'b1;
        data[i*DW +: DW] <= din;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   sec <= SEC_NONE;
    else if (wr && mask == '0)    sec <= sec_in;
  end
endmodule

// File: rtl/ccr_store.sv
module ccr_store
  import ccr_pkg::*;
#(
  parameter int ALM   = 8,
  parameter int CTL   = 4,
  parameter int TCB   = 8,
  parameter int SLOTS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit,
  input  sec_e                csec,
  input  logic [SLOTS*DW-1:0] cdata,
  input  logic [SLOTS-1:0]    cmask,
  input  logic                snap_cap,
  input  logic [TCB*DW-1:0]   tc_live,
  input  logic [ADDR_W-1:0]   raddr,
  output logic [DW-1:0]       rbyte,
  output logic [TCB*DW-1:0]   snap
);
  localparam int AOW = $clog2(ALM);
  localparam int COW = $clog2(CTL);
  localparam int TOW = $clog2(TCB);

  logic [DW-1:0] al0 [ALM];
  logic [DW-1:0] al1 [ALM];
  logic [DW-1:0] ctl [CTL];
  logic [DW-1:0] snb [TCB];

  for (genvar i = 0; i < ALM; i++) begin : g_alm
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        al0[i] <= '0;
        al1[i] <= '0;
      end else if (commit && cmask[i]) begin
        if (csec == SEC_AL0) al0[i] <= cdata[i*DW +: DW];
        if (csec == SEC_AL1) al1[i] <= cdata[i*DW +: DW];
      end
    end
  end

  for (genvar i = 0; i < CTL; i++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (!rst_n)                                   ctl[i] <= '0;
      else if (commit && cmask[i] && csec == SEC_CTL) ctl[i] <= cdata[i*DW +: DW];
    end
  end

  for (genvar i = 0; i < TCB; i++) begin : g_snap
    always_ff @(posedge clk) begin
      if (!rst_n)        snb[i] <= '0;
      else if (snap_cap) snb[i] <= tc_live[i*DW +: DW];
    end
    assign snap[i*DW +: DW] = snb[i];
  end

  always_comb begin
    case (sec_of(raddr))
      SEC_AL0: rbyte = al0[raddr[AOW-1:0]];
      SEC_AL1: rbyte = al1[raddr[AOW-1:0]];
      SEC_CTL: rbyte = ctl[raddr[COW-1:0]];
      SEC_TC:  rbyte = snb[raddr[TOW-1:0]];
      default: rbyte = '0;
    endcase
  end
endmodule

// File: rtl/ccr_access_ctl.sv
module ccr_access_ctl
  import ccr_pkg::*;
#(
  parameter int ALM_BYTES = 8,
  parameter int CTL_BYTES = 4,
  parameter int TC_BYTES  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ev_start,
  input  logic                   ev_stop,
  input  logic                   ev_dev,
  input  logic [7:0]             dev_byte,
  input  logic                   ev_addr,
  input  logic [7:0]             addr_byte,
  input  logic                   ev_wdat,
  input  logic [7:0]             wdat,
  input  logic                   ev_rreq,
  input  logic [TC_BYTES*8-1:0]  tc_live,
  output logic [7:0]             rd_data,
  output logic                   rd_valid,
  output logic                   tc_load,
  output logic [TC_BYTES*8-1:0]  tc_load_data,
  output logic [TC_BYTES-1:0]    tc_load_mask
);
  localparam int SLOTS = (ALM_BYTES > TC_BYTES) ? ALM_BYTES : TC_BYTES;

  // operation state
  logic op_sel, op_rd, op_addr_ok, op_dead, rd_any, stat_pend;
  logic [DW-1:0] stat_byte;

  // named internal events
  logic quiet, dev_match, addr_in_rng;
  logic acc_dev, acc_addr, acc_wdat, acc_rd;
  logic stat_extra, ptr_adv, ptr_load, rd_fire, wb_wr, wb_clr;
  logic commit_go, stat_go, snap_cap;
  sec_e cur_sec;

  logic [ADDR_W-1:0]   ptr;
  logic                wel, rwel;
  logic [SLOTS*DW-1:0] wb_data;
  logic [SLOTS-1:0]    wb_mask;
  sec_e                wb_sec;
  logic [DW-1:0]       st_rbyte, stat_val;
  logic [TC_BYTES*DW-1:0] snap;

  assign quiet       = !ev_stop && !ev_start;
  assign dev_match   = (dev_byte[7:1] == SEL_CODE);
  assign addr_in_rng = (addr_byte[7:6] == 2'b00);
  assign cur_sec     = sec_of(ptr);

  assign acc_dev  = quiet && ev_dev;
  assign acc_addr = quiet && !ev_dev && ev_addr && op_sel && !op_rd && !op_addr_ok;
  assign acc_wdat = quiet && !ev_dev && !ev_addr && ev_wdat &&
                    op_sel && !op_rd && op_addr_ok && !op_dead;
  assign acc_rd   = quiet && !ev_dev && !ev_addr && !ev_wdat && ev_rreq &&
                    op_sel && op_rd && !op_dead;

  assign stat_extra = (cur_sec == SEC_STAT) &&
                      ((acc_wdat && stat_pend) || (acc_rd && rd_any));
  assign ptr_load   = acc_addr && addr_in_rng;
  assign ptr_adv    = (acc_wdat || acc_rd) && !stat_extra;
  assign rd_fire    = acc_rd && !stat_extra;
  assign wb_wr      = acc_wdat && buffered_sec(cur_sec);
  assign wb_clr     = ev_start || ev_stop;
  assign commit_go  = ev_stop && rwel && (wb_mask != '0);
  assign stat_go    = ev_stop && stat_pend;
  assign snap_cap   = acc_dev && dev_match && dev_byte[0];

  always_comb begin
    stat_val           = '0;
    stat_val[WEL_POS]  = wel;
    stat_val[RWEL_POS] = rwel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_sel     <= 1'b0;
      op_rd      <= 1'b0;
      op_addr_ok <= 1'b0;
      op_dead    <= 1'b0;
      rd_any     <= 1'b0;
      stat_pend  <= 1'b0;
      stat_byte  <= '0;
    end else if (!quiet) begin
      op_sel     <= 1'b0;
      op_rd      <= 1'b0;
      op_addr_ok <= 1'b0;
      op_dead    <= 1'b0;
      rd_any     <= 1'b0;
      stat_pend  <= 1'b0;
    end else if (acc_dev) begin
      op_sel     <= dev_match;
      op_rd      <= dev_byte[0];
      op_addr_ok <= 1'b0;
      op_dead    <= 1'b0;
      rd_any     <= 1'b0;
      stat_pend  <= 1'b0;
    end else if (acc_addr) begin
      if (addr_in_rng) op_addr_ok <= 1'b1;
      else             op_sel     <= 1'b0;
    end else if (acc_wdat) begin
      if (stat_extra) op_dead <= 1'b1;
      else if (cur_sec == SEC_STAT) begin
        stat_pend <= 1'b1;
        stat_byte <= wdat;
      end
    end else if (acc_rd) begin
      if (stat_extra) op_dead <= 1'b1;
      else            rd_any  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= (cur_sec == SEC_STAT) ? stat_val : st_rbyte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc_load      <= 1'b0;
      tc_load_data <= '0;
      tc_load_mask <= '0;
    end else begin
      tc_load <= commit_go && wb_sec == SEC_TC;
      if (commit_go && wb_sec == SEC_TC) begin
        tc_load_data <= wb_data[TC_BYTES*DW-1:0];
        tc_load_mask <= wb_mask[TC_BYTES-1:0];
      end
    end
  end

  ccr_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_addr(addr_byte[ADDR_W-1:0]),
    .adv(ptr_adv), .ptr(ptr)
  );

  ccr_enable u_en (
    .clk(clk), .rst_n(rst_n), .upd(stat_go), .val(stat_byte), .wel(wel), .rwel(rwel)
  );

  ccr_wbuf #(.SLOTS(SLOTS)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .clr(wb_clr), .wr(wb_wr), .off(ptr[OFF_W-1:0]),
    .din(wdat), .sec_in(cur_sec), .data(wb_data), .mask(wb_mask), .sec(wb_sec)
  );

  ccr_store #(.ALM(ALM_BYTES), .CTL(CTL_BYTES), .TCB(TC_BYTES), .SLOTS(SLOTS)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit_go), .csec(wb_sec), .cdata(wb_data),
    .cmask(wb_mask), .snap_cap(snap_cap), .tc_live(tc_live), .raddr(ptr),
    .rbyte(st_rbyte), .snap(snap)
  );
endmodule

// File: rtl/ccr_access_chk.sv
module ccr_access_chk
  import ccr_pkg::*;
#(
  parameter int SNAP_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_start,
  input logic              ev_stop,
  input logic              ev_dev,
  input logic              ev_rreq,
  input logic              rd_valid,
  input logic              tc_load,
  input logic              wel,
  input logic              rwel,
  input logic [ADDR_W-1:0] ptr,
  input logic              ptr_adv,
  input logic              op_dead,
  input logic              op_sel,
  input logic              op_rd,
  input logic [SNAP_W-1:0] snap
);
  p_rwel_needs_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rwel |-> wel);

  p_rwel_armed_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rwel) |-> $past(wel));

  p_load_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tc_load |-> ($past(ev_stop) && $past(rwel)));

  p_wrap_in_section_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ptr_adv) |-> (sec_of(ptr) == sec_of($past(ptr))));

  p_read_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(ev_rreq));

  p_end_only_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_dead) |-> ($past(ptr) == STAT_ADDR));

  p_snapshot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel && op_rd && !ev_dev && !ev_start && !ev_stop) |=> $stable(snap));
endmodule

bind ccr_access_ctl ccr_access_chk #(.SNAP_W(TC_BYTES*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop), .ev_dev(ev_dev),
  .ev_rreq(ev_rreq), .rd_valid(rd_valid), .tc_load(tc_load), .wel(wel), .rwel(rwel),
  .ptr(ptr), .ptr_adv(ptr_adv), .op_dead(op_dead), .op_sel(op_sel), .op_rd(op_rd),
  .snap(snap)
);

// File: tb/sim_ccr_access_ctl.sv
module sim_ccr_access_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_start = 0, ev_stop = 0, ev_dev = 0, ev_addr = 0, ev_wdat = 0, ev_rreq = 0;
  logic [7:0] dev_byte = '0, addr_byte = '0, wdat = '0;
  logic [63:0] tc_live = 64'h0102030405060708;
  logic [7:0] rd_data;
  logic rd_valid, tc_load;
  logic [63:0] tc_load_data;
  logic [7:0] tc_load_mask;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  localparam logic [7:0] SELW = 8'hDE;
  localparam logic [7:0] SELR = 8'hDF;

  logic [7:0] m_mem [0:63];
  bit m_wel = 0, m_rwel = 0;
  logic [5:0] m_ptr = '0;
  logic [7:0] m_snap [0:7];
  logic [7:0] wd [0:15];

  always #5 clk = ~clk;

  ccr_access_ctl u0 (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop), .ev_dev(ev_dev),
    .dev_byte(dev_byte), .ev_addr(ev_addr), .addr_byte(addr_byte), .ev_wdat(ev_wdat),
    .wdat(wdat), .ev_rreq(ev_rreq), .tc_live(tc_live), .rd_data(rd_data),
    .rd_valid(rd_valid), .tc_load(tc_load), .tc_load_data(tc_load_data),
    .tc_load_mask(tc_load_mask)
  );

  function automatic int b_sec(logic [5:0] a);
    if (a < 6'd8)                  return 0;
    if (a < 6'd16)                 return 1;
    if (a < 6'd20)                 return 2;
    if (a >= 6'd48 && a < 6'd56)   return 3;
    if (a == 6'd63)                return 4;
    return 5;
  endfunction

  function automatic logic [5:0] b_next(logic [5:0] a);
    int s = b_sec(a);
    if (s == 0 || s == 1 || s == 3) return (a & 6'h38) | ((a + 6'd1) & 6'h07);
    if (s == 2)                     return 6'h10 | ((a + 6'd1) & 6'h03);
    return a;
  endfunction

  function automatic logic [7:0] b_val(logic [5:0] a);
    case (b_sec(a))
      0, 1, 2: return m_mem[a];
      3:       return m_snap[a - 6'd48];
      4:       return {5'b0, m_rwel, m_wel, 1'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one event for one cycle; entered and left at a falling edge
  task automatic ev1(input int kind, input logic [7:0] b);
    case (kind)
      0: ev_start = 1;
      1: ev_stop = 1;
      2: begin ev_dev = 1; dev_byte = b; end
      3: begin ev_addr = 1; addr_byte = b; end
      4: begin ev_wdat = 1; wdat = b; end
      default: ev_rreq = 1;
    endcase
    @(negedge clk);
    ev_start = 0; ev_stop = 0; ev_dev = 0; ev_addr = 0; ev_wdat = 0; ev_rreq = 0;
  endtask

  task automatic op_write(input logic [7:0] devb, input logic [7:0] addr, input int n,
                          input bit with_stop, input string tag);
    bit sel, dead = 0, stp = 0, any = 0, exp_load = 0;
    logic [7:0] sb = '0;
    logic [7:0] bm [0:63];
    bit bv [0:63];
    logic [7:0] emask = '0;
    for (int k = 0; k < 64; k++) begin bv[k] = 0; bm[k] = '0; end
    sel = (devb[7:1] == 7'h6F) && !devb[0];
    if (sel && addr < 8'd64) m_ptr = addr[5:0];
    else sel = 0;
    ev1(0, 0); ev1(2, devb); ev1(3, addr);
    for (int i = 0; i < n; i++) begin
      if (sel && !dead) begin
        if (b_sec(m_ptr) == 4) begin
          if (stp) dead = 1;
          else begin stp = 1; sb = wd[i]; end
        end else begin
          if (b_sec(m_ptr) < 4) begin
            bv[m_ptr] = 1; bm[m_ptr] = wd[i]; any = 1;
          end
          m_ptr = b_next(m_ptr);
        end
      end
      ev1(4, wd[i]);
    end
    if (with_stop) begin
      if (stp) begin
        if (sb == 8'h02) begin m_wel = 1; m_rwel = 0; end
        else if (sb == 8'h06 && m_wel) begin m_wel = 1; m_rwel = 1; end
        else begin m_wel = 0; m_rwel = 0; end
      end else if (any && m_rwel) begin
        for (int k = 0; k < 64; k++) if (bv[k]) begin
          if (b_sec(6'(k)) < 3) m_mem[k] = bm[k];
          else begin exp_load = 1; emask[k - 48] = 1'b1; end
        end
      end
      ev1(1, 0);
      chk({tag, " R7 tc_load"}, tc_load, exp_load);
      if (exp_load) begin
        chk("R7 mask", tc_load_mask, emask);
        for (int j = 0; j < 8; j++)
          if (emask[j]) chk("R7 data", tc_load_data[j*8 +: 8], bm[48 + j]);
      end
    end else begin
      ev1(0, 0);
      chk({tag, " R6 no load on restart"}, tc_load, 0);
      ev1(1, 0);
    end
  endtask

  task automatic op_read(input logic [7:0] devb, input logic [7:0] addr, input bit use_addr,
                         input int n, input string tag);
    bit sel, dead = 0, rdany = 0;
    sel = (devb[7:1] == 7'h6F);
    ev1(0, 0);
    if (use_addr) begin
      if (sel && addr < 8'd64) m_ptr = addr[5:0];
      ev1(2, {devb[7:1], 1'b0}); ev1(3, addr); ev1(0, 0);
    end
    sel = sel && devb[0];
    if (sel) for (int j = 0; j < 8; j++) m_snap[j] = tc_live[j*8 +: 8];
    ev1(2, devb);
    for (int i = 0; i < n; i++) begin
      bit ev;
      logic [7:0] ed;
      tc_live = {$urandom, $urandom};
      ev = 0; ed = 0;
      if (sel && !dead) begin
        if (b_sec(m_ptr) == 4 && rdany) dead = 1;
        else begin ev = 1; ed = b_val(m_ptr); rdany = 1; m_ptr = b_next(m_ptr); end
      end
      ev1(5, 0);
      chk({tag, " R12 rd_valid"}, rd_valid, ev);
      if (ev) chk({tag, " rd_data"}, rd_data, ed);
    end
    ev1(1, 0);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) m_mem[k] = '0;
    for (int k = 0; k < 8; k++) m_snap[k] = '0;
    for (int k = 0; k < 16; k++) wd[k] = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 rd_valid", rd_valid, 0);
    chk("R11 tc_load", tc_load, 0);
    op_read(SELR, 8'h00, 1, 3, "R11");
    op_read(SELR, 8'h3F, 1, 1, "R11");
    // write without enable is dropped
    wd[0] = 8'hAA;
    op_write(SELW, 8'h05, 1, 1, "R6");
    op_read(SELR, 8'h05, 1, 1, "R6");
    // two-step enable, including a set attempt without arming
    wd[0] = 8'h06; op_write(SELW, 8'h3F, 1, 1, "R5");
    op_read(SELR, 8'h3F, 1, 1, "R5");
    wd[0] = 8'h02; op_write(SELW, 8'h3F, 1, 1, "R5");
    op_read(SELR, 8'h3F, 1, 1, "R5");
    wd[0] = 8'h06; op_write(SELW, 8'h3F, 1, 1, "R5");
    op_read(SELR, 8'h3F, 1, 1, "R5");
    // section wrap in alarm B and control
    wd[0] = 8'h11; wd[1] = 8'h22; wd[2] = 8'h33; wd[3] = 8'h44;
    op_write(SELW, 8'h0E, 4, 1, "R3");
    op_read(SELR, 8'h0E, 1, 5, "R3");
    op_write(SELW, 8'h12, 3, 1, "R3");
    op_read(SELR, 8'h12, 1, 5, "R3");
    op_read(SELR, 8'h00, 0, 3, "R9");
    // foreign device select
    wd[0] = 8'h5A;
    op_write(8'hA0, 8'h01, 1, 1, "R1");
    op_read(SELR, 8'h01, 1, 1, "R1");
    op_read(8'hA1, 8'h00, 0, 2, "R1");
    // address out of range
    op_write(SELW, 8'h45, 2, 1, "R2");
    op_read(SELR, 8'h00, 0, 1, "R2");
    // repeated start discards the buffer
    op_write(SELW, 8'h02, 1, 0, "R6");
    op_read(SELR, 8'h02, 1, 1, "R6");
    // time section with wrap
    wd[0] = 8'hC1; wd[1] = 8'hC2; wd[2] = 8'hC3;
    op_write(SELW, 8'h36, 3, 1, "R7");
    // snapshot consistency across a full time read
    op_read(SELR, 8'h30, 1, 9, "R8");
    // status takes a single byte
    wd[0] = 8'h02; wd[1] = 8'h00;
    op_write(SELW, 8'h3F, 2, 1, "R4");
    op_read(SELR, 8'h3F, 1, 3, "R4");
    // undefined addresses
    op_read(SELR, 8'h20, 1, 2, "R10");
    op_read(SELR, 8'h00, 0, 1, "R10");
    wd[0] = 8'h06; op_write(SELW, 8'h3F, 1, 1, "R5");
    wd[0] = 8'h77; op_write(SELW, 8'h2A, 2, 1, "R10");
    op_read(SELR, 8'h2A, 1, 1, "R10");
    // random mix
    for (int r = 0; r < 300; r++) begin
      int kind, n, w;
      logic [7:0] a, d;
      w = $urandom % 5;
      case (w)
        0: a = 8'($urandom % 16);
        1: a = 8'(16 + $urandom % 4);
        2: a = 8'(48 + $urandom % 8);
        3: a = 8'h3F;
        default: a = 8'($urandom % 72);
      endcase
      d = ($urandom % 8 == 0) ? 8'($urandom) : SELW;
      n = 1 + $urandom % 10;
      kind = $urandom % 7;
      for (int k = 0; k < 16; k++) wd[k] = 8'($urandom);
      case (kind)
        0: begin wd[0] = 8'h02; op_write(SELW, 8'h3F, 1, 1, "R5 rnd"); end
        1: begin wd[0] = ($urandom % 4 == 0) ? 8'h00 : 8'h06;
                 op_write(SELW, 8'h3F, 1 + $urandom % 2, 1, "R5 rnd"); end
        2, 3: op_write(d, a, n, ($urandom % 6) != 0, "R6 rnd");
        4, 5: op_read({d[7:1], 1'b1}, a, 1, n, "R3 rnd");
        default: op_read(SELR, 8'h00, 0, 1 + $urandom % 4, "R9 rnd");
      endcase
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule